// File: doc/BRIEF.md
# Keyboard Host Command Sequencer

This block issues configuration commands from a host controller to a PS/2 keyboard and judges the keyboard's replies. A single request pulse selects one of four operations: program the three lock indicators, run an echo test, ask for a repeat of the last scan code, or reset the keyboard. The sequencer hands each command byte to a host-side PS/2 byte transmitter through a valid/ready handshake. It then watches the receive byte stream for the reply that the command calls for.

The indicator operation runs in two phases. After the command byte is sent, the sequencer waits for an acknowledge. Only then does it send the indicator byte, and it waits for a second acknowledge before it reports success. Each reply wait has a bounded timeout in clock cycles. A missing reply or a wrong byte ends the operation with an error pulse. Receive bytes that arrive while no reply is expected are only observed and have no effect on the sequencer.

Top module: `kbd_cmd_seq`

## Requirements
- R1: During and right after synchronous reset (`rst` high), `busy`, `done`, `error` and `tx_valid` are all low.
- R2: A `cmd_req` pulse while idle raises `busy` on the next cycle and presents the command byte on `tx_byte` with `tx_valid` high. `cmd_sel` is encoded 0 = indicators (0xED), 1 = echo (0xEE), 2 = resend (0xFE), 3 = reset (0xFF).
- R3: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_byte` is unchanged. Exactly one byte is transferred per handshake.
- R4: For the indicator operation, the argument byte is sent only after the reply 0xFA. It is `{5'b0, led_bits}`, where `led_bits[0]` is Scroll Lock, `led_bits[1]` is Num Lock and `led_bits[2]` is Caps Lock.
- R5: The indicator operation reports `done` only after a second 0xFA follows the argument byte.
- R6: The echo operation reports `done` only when the reply is 0xEE.
- R7: The resend operation accepts any reply byte as success. The reset operation succeeds on the reply 0xFA.
- R8: A reply byte other than the expected one gives an `error` pulse and returns the sequencer to idle without sending further bytes.
- R9: If `TIMEOUT_CYCLES` cycles pass in a reply wait with no `rx_valid`, the sequencer raises `error` and returns to idle. No error is raised before that.
- R10: `cmd_req` has no effect while `busy` is high.
- R11: Receive bytes that arrive while no reply is awaited (idle, or while a byte is being sent) do not change the outcome of any operation.
- R12: `done` and `error` are single-cycle pulses that never coincide. Each appears in the first cycle in which `busy` is low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_req | input | 1 | Start pulse for an operation |
| cmd_sel | input | 2 | Operation select |
| led_bits | input | 3 | Indicator states for the indicator operation |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_byte | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter accepts the byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Success pulse |
| error | output | 1 | Failure pulse (wrong reply or timeout) |

## Verification
The assertions assume that the transmitter behind `tx_ready` eventually accepts each byte. They also assume that `rx_valid` is a one-cycle strobe per received byte and that `cmd_sel` and `led_bits` are valid in the cycle of `cmd_req`. The stimulus drives every input shortly after the rising edge, so values are stable across each edge. It issues receive strobes one cycle wide and holds `tx_ready` low only for a bounded stall. Requests during a busy operation and bytes arriving outside a reply wait are sent on purpose. The interface permits them, so they test robustness and do not break the assumptions.

// File: rtl/kbd_cmd_pkg.sv
package kbd_cmd_pkg;

    typedef enum logic [1:0] {
        OP_LEDS   = 2'd0,
        OP_ECHO   = 2'd1,
        OP_RESEND = 2'd2,
        OP_RESET  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND_CMD,
        ST_WAIT_R1,
        ST_SEND_ARG,
        ST_WAIT_R2
    } st_e;

    typedef struct packed {
        op_e        op;
        logic [2:0] leds;
    } job_t;

    localparam logic [7:0] KB_ACK  = 8'hFA;
    localparam logic [7:0] KB_ECHO = 8'hEE;

    function automatic logic [7:0] op_byte(op_e op);
        case (op)
            OP_LEDS:   return 8'hED;
            OP_ECHO:   return 8'hEE;
            OP_RESEND: return 8'hFE;
            default:   return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] first_reply(op_e op);
        return (op == OP_ECHO) ? KB_ECHO : KB_ACK;
    endfunction

    function automatic logic reply_is_free(op_e op);
        return op == OP_RESEND;
    endfunction

    function automatic logic [7:0] led_arg(logic [2:0] leds);
        return {5'b0, leds};
    endfunction

endpackage

// File: rtl/kbd_reply_timer.sv
module kbd_reply_timer #(
    parameter int TIMEOUT_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(TIMEOUT_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (arm) begin
            cnt <= LOAD;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && (cnt == '0);

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LOAD); // R9

endmodule

// File: rtl/kbd_reply_check.sv
module kbd_reply_check
    import kbd_cmd_pkg::*;
(
    input  op_e        op,
    input  logic       second,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic       hit,
    output logic       miss
);
    logic good;

    always_comb begin
        if (second) good = (rx_byte == KB_ACK);
        else        good = reply_is_free(op) || (rx_byte == first_reply(op));
        hit  = rx_valid && good;
        miss = rx_valid && !good;
    end

endmodule

// File: rtl/kbd_cmd_seq.sv
module kbd_cmd_seq
    import kbd_cmd_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_req,
    input  logic [1:0] cmd_sel,
    input  logic [2:0] led_bits,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    input  logic       tx_ready,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic       busy,
    output logic       done,
    output logic       error
);
    st_e  state;
    job_t job;
    logic waiting, second, hit, miss, expired, xfer;

    assign waiting  = (state == ST_WAIT_R1) || (state == ST_WAIT_R2);
    assign second   = (state == ST_WAIT_R2);
    assign tx_valid = (state == ST_SEND_CMD) || (state == ST_SEND_ARG);
    assign tx_byte  = (state == ST_SEND_ARG) ? led_arg(job.leds) : op_byte(job.op);
    assign busy     = (state != ST_IDLE);
    assign xfer     = tx_valid && tx_ready;

    kbd_reply_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .arm     (xfer),
        .run     (waiting),
        .expired (expired)
    );

    kbd_reply_check u_check (
        .op       (job.op),
        .second   (second),
        .rx_valid (rx_valid && waiting),
        .rx_byte  (rx_byte),
        .hit      (hit),
        .miss     (miss)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            job   <= '0;
            done  <= 1'b0;
            error <= 1'b0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            case (state)
                ST_IDLE: if (cmd_req) begin
                    job   <= '{op: op_e'(cmd_sel), leds: led_bits};
                    state <= ST_SEND_CMD;
                end
                ST_SEND_CMD: if (tx_ready) state <= ST_WAIT_R1;
                ST_SEND_ARG: if (tx_ready) state <= ST_WAIT_R2;
                ST_WAIT_R1, ST_WAIT_R2: begin
                    if (hit) begin
                        if (state == ST_WAIT_R1 && job.op == OP_LEDS) begin
                            state <= ST_SEND_ARG;
                        end else begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end
                    end else if (miss || expired) begin
                        state <= ST_IDLE;
                        error <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tx_valid); // R2
    AST_START_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_req)); // R10
    AST_END_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && error)); // R12
    AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> !busy && $past(busy)); // R12
    AST_LED_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        tx_valid && $past(rx_valid) && $past(state == ST_WAIT_R1) |-> tx_byte[7:3] == 5'b0); // R4

endmodule

// File: tb/kbd_cmd_seq_tb.sv
module kbd_cmd_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 40;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_req = 1'b0;
    logic [1:0] cmd_sel = 2'd0;
    logic [2:0] led_bits = 3'd0;
    logic       tx_ready = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_valid, busy, done, error;
    logic [7:0] tx_byte;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_tx[$];
    bit         exp_ok[$];
    string      exp_tag[$];
    bit         prev_end = 1'b0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbd_cmd_seq #(.TIMEOUT_CYCLES(TMO)) u_dut (
        .clk(clk), .rst(rst), .cmd_req(cmd_req), .cmd_sel(cmd_sel),
        .led_bits(led_bits), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .busy(busy), .done(done), .error(error)
    );

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cmd_code(input logic [1:0] sel);
        case (sel)
            2'd0: return 8'hED;
            2'd1: return 8'hEE;
            2'd2: return 8'hFE;
            default: return 8'hFF;
        endcase
    endfunction

    // monitor: compares transfers and outcome pulses against the queues
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0) chk("R10 unexpected tx byte", 1'b0, tx_byte, 0);
                else begin
                    logic [7:0] e;
                    e = exp_tx.pop_front();
                    chk("R2/R4 tx byte", tx_byte == e, tx_byte, e);
                end
            end
            if (done || error) begin
                chk("R12 done/error exclusive", !(done && error), {done, error}, 1);
                chk("R12 busy low at outcome", !busy, busy, 0);
                chk("R12 single-cycle pulse", !prev_end, prev_end, 0);
                if (exp_ok.size() == 0) chk("R11 unexpected outcome", 1'b0, done, 0);
                else begin
                    bit    o;
                    string t;
                    o = exp_ok.pop_front();
                    t = exp_tag.pop_front();
                    chk(t, done == o, done, o);
                    chk({t, " all bytes sent first"}, exp_tx.size() == 0, exp_tx.size(), 0);
                end
            end
            prev_end = done || error;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_rx(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        tick(1);
        rx_valid = 1'b0;
    endtask

    task automatic do_cmd(input string tag, input logic [1:0] sel, input logic [2:0] led,
                          input bit s1, input logic [7:0] r1,
                          input bit s2, input logic [7:0] r2,
                          input bit exp_arg, input bit ok, input bit spam);
        exp_tx.push_back(cmd_code(sel));
        if (exp_arg) exp_tx.push_back({5'b0, led});
        exp_ok.push_back(ok);
        exp_tag.push_back(tag);
        cmd_sel = sel; led_bits = led; cmd_req = 1'b1;
        tick(1);
        cmd_req = 1'b0;
        chk({tag, " R2 busy after request"}, busy, busy, 1);
        if (spam) begin
            cmd_sel = 2'd3; cmd_req = 1'b1;
            tick(2);
            cmd_req = 1'b0;
        end else tick(2);
        if (s1) send_rx(r1);
        else begin
            tick(TMO - 4);
            chk({tag, " R9 no early timeout"}, exp_ok.size() == 1, exp_ok.size(), 1);
        end
        tick(3);
        if (s2) send_rx(r2);
        else tick(TMO + 6);
        tick(4);
        chk({tag, " outcome seen"}, exp_ok.size() == 0 && exp_tx.size() == 0, exp_ok.size(), 0);
        chk({tag, " idle after"}, !busy, busy, 0);
    endtask

    initial begin
        tick(3);
        chk("R1 reset busy", !busy, busy, 0);
        chk("R1 reset done/error", !done && !error, {done, error}, 0);
        chk("R1 reset tx_valid", !tx_valid, tx_valid, 0);
        rst = 1'b0;
        tick(2);
        chk("R1 idle after reset", !busy && !tx_valid, {busy, tx_valid}, 0);

        do_cmd("R5 leds 101 done", 2'd0, 3'b101, 1, 8'hFA, 1, 8'hFA, 1, 1, 0);
        do_cmd("R4 leds 010 done", 2'd0, 3'b010, 1, 8'hFA, 1, 8'hFA, 1, 1, 0);
        do_cmd("R8 leds bad 2nd reply", 2'd0, 3'b111, 1, 8'hFA, 1, 8'hFE, 1, 0, 0);
        do_cmd("R8 leds bad 1st reply", 2'd0, 3'b001, 1, 8'hAA, 1, 8'hFA, 0, 0, 0);
        do_cmd("R6 echo done", 2'd1, 3'b000, 1, 8'hEE, 0, 8'h00, 0, 1, 0);
        do_cmd("R6 echo wrong reply", 2'd1, 3'b000, 1, 8'hFA, 0, 8'h00, 0, 0, 0);
        do_cmd("R7 resend any byte", 2'd2, 3'b000, 1, 8'h1C, 0, 8'h00, 0, 1, 0);
        do_cmd("R7 reset ack", 2'd3, 3'b000, 1, 8'hFA, 0, 8'h00, 0, 1, 0);
        do_cmd("R8 reset wrong", 2'd3, 3'b000, 1, 8'hAA, 0, 8'h00, 0, 0, 0);
        do_cmd("R9 echo timeout", 2'd1, 3'b000, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        do_cmd("R9 leds 2nd timeout", 2'd0, 3'b100, 1, 8'hFA, 0, 8'h00, 1, 0, 0);
        do_cmd("R10 request while busy", 2'd1, 3'b000, 1, 8'hEE, 0, 8'h00, 0, 1, 1);

        // R11: bytes while idle do not satisfy a later wait
        send_rx(8'hEE);
        send_rx(8'hFA);
        tick(2);
        chk("R11 idle bytes no outcome", !busy && !done && !error, {busy, done, error}, 0);
        do_cmd("R11 echo after idle bytes times out", 2'd1, 3'b000, 0, 8'h00, 0, 8'h00, 0, 0, 0);

        // R3 stall with R11 byte during send
        tx_ready = 1'b0;
        exp_tx.push_back(8'hFF);
        exp_ok.push_back(1'b1);
        exp_tag.push_back("R3 stalled reset done");
        cmd_sel = 2'd3; cmd_req = 1'b1;
        tick(1);
        cmd_req = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk("R3 tx held during stall", tx_valid && tx_byte == 8'hFF, tx_byte, 8'hFF);
            if (i == 1) send_rx(8'hFA);
            else tick(1);
        end
        chk("R11 byte during send ignored", busy && exp_ok.size() == 1, exp_ok.size(), 1);
        tx_ready = 1'b1;
        tick(1);
        tick(2);
        chk("R3 tx dropped after handshake", !tx_valid, tx_valid, 0);
        send_rx(8'hFA);
        tick(4);
        chk("R3 stalled op completed", exp_ok.size() == 0 && exp_tx.size() == 0, exp_ok.size(), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule